// File: doc/BRIEF.md
# Interrupt Condition and Mask Unit

This unit sits beside the transfer engine of a two-wire serial bus controller and owns the controller's status word, its interrupt mask and the single level interrupt that goes to the host. The transfer logic reports events through per-bit set and clear strobes. The upper half of the status word is the event half. Bits 31..16 of the status word are presented as the raw interrupt condition in bits 15..0. The masked condition is the raw condition ANDed with a 16-bit mask. The interrupt output is high whenever the masked condition is nonzero.

Software reaches the unit through a 64-bit register port. The word offset is the byte address divided by 8. Two offsets behave differently for reads and writes. A read returns a condition view. A write to the same offset sets bits in the mask (OR) or keeps only some mask bits (AND). Two write-only offsets reset state. One clears only the error bits. The other clears the whole unit. The unit also flags accesses to offsets that no register owns. Registers that belong to neighbouring logic are read through a pass-through data input. The unit emits one-cycle strobes so that the neighbours can zero their own registers or flush the data FIFO.

Status bit map (bit 31 down): 31 invalid-command, 30 parity error, 29 back-end overrun, 28 back-end access error, 27 arbitration lost, 26 NACK received, 25 data request, 24 command done, 23 stop error. The error bits are 31..26 and 23 (mask 0xFC80_0000).

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the status word is 0x0100_0000 (command-done only), the mask is zero, the interrupt output is low and no read data is valid.
- R2: A read of offset 0x9 returns status bits 31..16 in data bits 15..0. A read of offset 0xA returns that value ANDed with the mask. All higher data bits are zero.
- R3: The interrupt output is high exactly when (status[31:16] & mask) is nonzero. It follows the register state in the cycle after any access or status event.
- R4: A write to offset 0x8 loads the mask from write-data bits 15..0. A write to 0x9 ORs those bits into the mask. A write to 0xA ANDs those bits into the mask.
- R5: A read request returns its data one cycle later with the read-valid output high for that cycle. Offset 0x8 returns the mask. Offset 0xB returns the status word. Offset 0xE returns one busy bit per port, port i in bit i. Offsets 0x4–0x7, 0xC and 0xD return the neighbour read data. Writes produce no read-valid.
- R6: A write to offset 0xC clears only the error bits 31..26 and 23 of the status word. It also pulses the FIFO-flush and residual-clear outputs for one cycle.
- R7: A write to offset 0xB zeroes the status word and the mask. It also pulses the configuration-clear and residual-clear outputs for one cycle.
- R8: A read of an offset outside 0x4–0xE, or a write to an offset outside 0x4–0x11, sets status bit 31. Such a read returns all ones.
- R9: The status clear strobe acts first. The access effects act next. The status set strobe and the invalid-command flag are applied last, so a set in the same cycle survives a clear or a reset write.
- R10: Byte-address bits 2..0 are ignored. Only bits above them select the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W+3 | Byte address; offset = address / 8 |
| req_wdata_i | input | DATA_W | Write data |
| stat_set_i | input | 32 | Per-bit status set strobes from transfer logic |
| stat_clr_i | input | 32 | Per-bit status clear strobes from transfer logic |
| port_busy_i | input | NPORTS | Busy level of each bus port |
| nbr_rdata_i | input | DATA_W | Read data of neighbour-owned registers |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| status_o | output | 32 | Current status word |
| irq_o | output | 1 | Level interrupt |
| cfg_clr_o | output | 1 | Pulse: neighbours zero mode, command, watermark, extended status |
| resid_clr_o | output | 1 | Pulse: neighbours zero the residual counts |
| fifo_flush_o | output | 1 | Pulse: neighbours empty the data FIFO |

## Verification
The mask is driven through replace, OR and AND writes, and the bench then reads it back. The interrupt level is compared against status events that land on masked bits and on unmasked bits, which shows whether the AND with the mask happens before the reduction. Status strobes are sent in the same cycle as clear strobes and reset writes, which exposes any wrong ordering of the status update. Reads of every offset class, including ones with nonzero low address bits and unknown offsets, tell apart the raw view, the masked view, the port map and the pass-through path.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam int STAT_W   = 32;
  localparam int COND_W   = 16;
  localparam int COND_LSB = STAT_W - COND_W;

  localparam int B_INV   = 31;
  localparam int B_PAR   = 30;
  localparam int B_OVR   = 29;
  localparam int B_ACC   = 28;
  localparam int B_ARB   = 27;
  localparam int B_NACK  = 26;
  localparam int B_DREQ  = 25;
  localparam int B_DONE  = 24;
  localparam int B_STOPE = 23;

  localparam logic [STAT_W-1:0] ERR_BITS =
    (STAT_W'(1) << B_INV) | (STAT_W'(1) << B_PAR) | (STAT_W'(1) << B_OVR) |
    (STAT_W'(1) << B_ACC) | (STAT_W'(1) << B_ARB) | (STAT_W'(1) << B_NACK) |
    (STAT_W'(1) << B_STOPE);

  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << B_DONE;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_NBR,
    ACC_MASK,
    ACC_RAW,
    ACC_MASKED,
    ACC_STAT,
    ACC_PORTS,
    ACC_OR,
    ACC_AND,
    ACC_FULL,
    ACC_ERR,
    ACC_BAD
  } acc_e;

  function automatic acc_e classify(input logic we, input logic [15:0] off);
    acc_e a;
    a = ACC_BAD;
    if (!we) begin
      unique case (off)
        16'h4, 16'h5, 16'h6, 16'h7, 16'hC, 16'hD: a = ACC_NBR;
        16'h8: a = ACC_MASK;
        16'h9: a = ACC_RAW;
        16'hA: a = ACC_MASKED;
        16'hB: a = ACC_STAT;
        16'hE: a = ACC_PORTS;
        default: a = ACC_BAD;
      endcase
    end else begin
      unique case (off)
        16'h8: a = ACC_MASK;
        16'h9: a = ACC_OR;
        16'hA: a = ACC_AND;
        16'hB: a = ACC_FULL;
        16'hC: a = ACC_ERR;
        16'h4, 16'h5, 16'h6, 16'h7, 16'hD, 16'hE,
        16'hF, 16'h10, 16'h11: a = ACC_NONE;
        default: a = ACC_BAD;
      endcase
    end
    return a;
  endfunction

  function automatic logic [COND_W-1:0] raw_cond(input logic [STAT_W-1:0] st);
    return st[STAT_W-1:COND_LSB];
  endfunction

  function automatic logic [COND_W-1:0] masked_cond(input logic [STAT_W-1:0] st,
                                                    input logic [COND_W-1:0] m);
    return raw_cond(st) & m;
  endfunction

  function automatic logic irq_level(input logic [STAT_W-1:0] st,
                                     input logic [COND_W-1:0] m);
    return |masked_cond(st, m);
  endfunction

  function automatic logic [STAT_W-1:0] drop_errors(input logic [STAT_W-1:0] st);
    return st & ~ERR_BITS;
  endfunction

endpackage

// File: rtl/isu_decode.sv
module isu_decode
  import isu_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] off_i,
  output acc_e              acc_o,
  output logic              rd_en_o,
  output logic              mask_ld_o,
  output logic              mask_or_o,
  output logic              mask_and_o,
  output logic              full_rst_o,
  output logic              err_rst_o,
  output logic              bad_o
);

  localparam int OFF_EXT = 16;

  logic [OFF_EXT-1:0] off_ext;
  assign off_ext = OFF_EXT'(off_i);

  always_comb begin
    acc_o      = classify(we_i, off_ext);
    rd_en_o    = valid_i && !we_i;
    mask_ld_o  = valid_i && we_i && (acc_o == ACC_MASK);
    mask_or_o  = valid_i && (acc_o == ACC_OR);
    mask_and_o = valid_i && (acc_o == ACC_AND);
    full_rst_o = valid_i && (acc_o == ACC_FULL);
    err_rst_o  = valid_i && (acc_o == ACC_ERR);
    bad_o      = valid_i && (acc_o == ACC_BAD);
  end

endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              or_i,
  input  logic              and_i,
  input  logic              clr_i,
  input  logic [COND_W-1:0] wdata_i,
  output logic [COND_W-1:0] mask_o
);

  logic [COND_W-1:0] mask_q;
  logic [COND_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr_i)      mask_d = '0;
    else if (ld_i)  mask_d = wdata_i;
    else if (or_i)  mask_d = mask_q | wdata_i;
    else if (and_i) mask_d = mask_q & wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/isu_status_reg.sv
module isu_status_reg
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              full_rst_i,
  input  logic              err_rst_i,
  input  logic              bad_i,
  output logic [STAT_W-1:0] stat_o
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] after_clr;
  logic [STAT_W-1:0] after_acc;
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    after_clr = stat_q & ~clr_i;
    if (full_rst_i)     after_acc = '0;
    else if (err_rst_i) after_acc = drop_errors(after_clr);
    else                after_acc = after_clr;
    stat_d = after_acc | set_i;
    if (bad_i) stat_d[B_INV] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
  import isu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  acc_e              acc_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [COND_W-1:0] mask_i,
  input  logic [NPORTS-1:0] ports_i,
  input  logic [DATA_W-1:0] nbr_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] port_word;
  logic [DATA_W-1:0] sel;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < DATA_W; g++) begin : g_port_bits
    if (g < NPORTS) begin : g_live
      assign port_word[g] = ports_i[g];
    end else begin : g_zero
      assign port_word[g] = 1'b0;
    end
  end

  always_comb begin
    unique case (acc_i)
      ACC_MASK:   sel = DATA_W'(mask_i);
      ACC_RAW:    sel = DATA_W'(raw_cond(stat_i));
      ACC_MASKED: sel = DATA_W'(masked_cond(stat_i, mask_i));
      ACC_STAT:   sel = DATA_W'(stat_i);
      ACC_PORTS:  sel = port_word;
      ACC_NBR:    sel = nbr_i;
      default:    sel = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= sel;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import isu_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64,
  parameter int NPORTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [ADDR_W+2:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [STAT_W-1:0]   stat_set_i,
  input  logic [STAT_W-1:0]   stat_clr_i,
  input  logic [NPORTS-1:0]   port_busy_i,
  input  logic [DATA_W-1:0]   nbr_rdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [STAT_W-1:0]   status_o,
  output logic                irq_o,
  output logic                cfg_clr_o,
  output logic                resid_clr_o,
  output logic                fifo_flush_o
);

  localparam int BYTE_LSB = 3;

  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] req_off;
  acc_e              acc;
  logic              rd_en;
  logic              mask_ld;
  logic              mask_or;
  logic              mask_and;
  logic              full_rst;
  logic              err_rst;
  logic              bad_acc;
  logic [COND_W-1:0] mask_q;
  logic [STAT_W-1:0] status_q;
  logic              cfg_clr_q;
  logic              resid_clr_q;
  logic              flush_q;
  logic              unused_bits;

  assign req_off     = req_addr_i[ADDR_W+2:BYTE_LSB];
  assign unused_bits = ^{req_addr_i[BYTE_LSB-1:0], req_wdata_i[DATA_W-1:COND_W]};

  isu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i    (req_valid_i),
    .we_i       (req_we_i),
    .off_i      (req_off),
    .acc_o      (acc),
    .rd_en_o    (rd_en),
    .mask_ld_o  (mask_ld),
    .mask_or_o  (mask_or),
    .mask_and_o (mask_and),
    .full_rst_o (full_rst),
    .err_rst_o  (err_rst),
    .bad_o      (bad_acc)
  );

  isu_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (mask_ld),
    .or_i    (mask_or),
    .and_i   (mask_and),
    .clr_i   (full_rst),
    .wdata_i (req_wdata_i[COND_W-1:0]),
    .mask_o  (mask_q)
  );

  isu_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (stat_set_i),
    .clr_i      (stat_clr_i),
    .full_rst_i (full_rst),
    .err_rst_i  (err_rst),
    .bad_i      (bad_acc),
    .stat_o     (status_q)
  );

  isu_read_mux #(.DATA_W(DATA_W), .NPORTS(NPORTS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en_i  (rd_en),
    .acc_i    (acc),
    .stat_i   (status_q),
    .mask_i   (mask_q),
    .ports_i  (port_busy_i),
    .nbr_i    (nbr_rdata_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_clr_q   <= 1'b0;
      resid_clr_q <= 1'b0;
      flush_q     <= 1'b0;
    end else begin
      cfg_clr_q   <= full_rst;
      resid_clr_q <= full_rst || err_rst;
      flush_q     <= err_rst;
    end
  end

  assign status_o     = status_q;
  assign irq_o        = irq_level(status_q, mask_q);
  assign cfg_clr_o    = cfg_clr_q;
  assign resid_clr_o  = resid_clr_q;
  assign fifo_flush_o = flush_q;

endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [ADDR_W+2:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [STAT_W-1:0] stat_set_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [STAT_W-1:0] status_o,
  input logic [COND_W-1:0] mask_q,
  input logic              cfg_clr_o,
  input logic              resid_clr_o,
  input logic              fifo_flush_o
);

  logic [ADDR_W-1:0] off;
  logic              wr;
  logic              rd;
  assign off = req_addr_i[ADDR_W+2:3];
  assign wr  = req_valid_i && req_we_i;
  assign rd  = req_valid_i && !req_we_i;

  // R4
  mask_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == ADDR_W'(9)) |=> mask_q == ($past(mask_q) | $past(req_wdata_i[COND_W-1:0])));

  // R4
  mask_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == ADDR_W'(10)) |=> mask_q == ($past(mask_q) & $past(req_wdata_i[COND_W-1:0])));

  // R7
  full_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == ADDR_W'(11)) |=>
      (mask_q == '0) && (status_o == $past(stat_set_i)) && cfg_clr_o && resid_clr_o);

  // R6
  err_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == ADDR_W'(12)) |=>
      ((status_o & ERR_BITS) == ($past(stat_set_i) & ERR_BITS)) &&
      fifo_flush_o && resid_clr_o && !cfg_clr_o);

  // R5
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid_o);

  // R5
  no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid_o);

  // R8
  bad_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (off < ADDR_W'(4) || off > ADDR_W'(14))) |=> ((&rdata_o) && status_o[B_INV]));

endmodule

bind irq_stat_unit isu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_we_i     (req_we_i),
  .req_addr_i   (req_addr_i),
  .req_wdata_i  (req_wdata_i),
  .stat_set_i   (stat_set_i),
  .rvalid_o     (rvalid_o),
  .rdata_o      (rdata_o),
  .status_o     (status_o),
  .mask_q       (mask_q),
  .cfg_clr_o    (cfg_clr_o),
  .resid_clr_o  (resid_clr_o),
  .fifo_flush_o (fifo_flush_o)
);

// File: tb/irq_stat_unit_tb.sv
module irq_stat_unit_tb;

  localparam int PER    = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 64;
  localparam int NPORTS = 4;
  localparam logic [31:0] ERRM = 32'hFC80_0000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_we_i = 1'b0;
  logic [ADDR_W+2:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic [31:0]       stat_set_i = '0;
  logic [31:0]       stat_clr_i = '0;
  logic [NPORTS-1:0] port_busy_i = '0;
  logic [DATA_W-1:0] nbr_rdata_i = '0;
  logic              rvalid_o;
  logic [DATA_W-1:0] rdata_o;
  logic [31:0]       status_o;
  logic              irq_o;
  logic              cfg_clr_o;
  logic              resid_clr_o;
  logic              fifo_flush_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [31:0] m_stat;
  logic [15:0] m_mask;

  always #(PER/2) clk = ~clk;

  irq_stat_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(NPORTS)) u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit read_known(int off);
    return off >= 4 && off <= 14;
  endfunction

  function automatic bit write_known(int off);
    return off >= 4 && off <= 17;
  endfunction

  function automatic logic [63:0] exp_read(int off);
    if (!read_known(off)) return {64{1'b1}};
    if (off == 8)  return {48'h0, m_mask};
    if (off == 9)  return {48'h0, m_stat[31:16]};
    if (off == 10) return {48'h0, m_stat[31:16] & m_mask};
    if (off == 11) return {32'h0, m_stat};
    if (off == 14) return {60'h0, port_busy_i};
    return nbr_rdata_i;
  endfunction

  task automatic step(bit v, bit we, int off, logic [2:0] lo, logic [63:0] wd,
                      logic [31:0] set, logic [31:0] clr, string tag);
    logic [63:0] e_rd;
    logic [31:0] ns;
    bit bad, e_cfg, e_flush;
    req_valid_i = v;
    req_we_i    = we;
    req_addr_i  = {5'(off), lo};
    req_wdata_i = wd;
    stat_set_i  = set;
    stat_clr_i  = clr;
    e_rd = exp_read(off);
    ns = m_stat & ~clr;
    bad = 0;
    e_cfg = v && we && off == 11;
    e_flush = v && we && off == 12;
    if (v && we) begin
      if (off == 8) m_mask = wd[15:0];
      else if (off == 9) m_mask = m_mask | wd[15:0];
      else if (off == 10) m_mask = m_mask & wd[15:0];
      else if (off == 11) begin ns = 32'h0; m_mask = 16'h0; end
      else if (off == 12) ns = ns & ~ERRM;
      else if (!write_known(off)) bad = 1;
    end
    if (v && !we && !read_known(off)) bad = 1;
    ns = ns | set;
    if (bad) ns[31] = 1'b1;
    m_stat = ns;
    @(posedge clk);
    #(PER/4);
    chk("R5 rvalid", 64'(rvalid_o), 64'(v && !we));
    if (v && !we) chk(tag, rdata_o, e_rd);
    chk("R9 status", 64'(status_o), 64'(m_stat));
    chk("R3 irq", 64'(irq_o), 64'(|(m_stat[31:16] & m_mask)));
    chk("R7 cfg_clr", 64'(cfg_clr_o), 64'(e_cfg));
    chk("R6 flush", 64'(fifo_flush_o), 64'(e_flush));
    chk("R6 resid_clr", 64'(resid_clr_o), 64'(e_cfg || e_flush));
    @(negedge clk);
    req_valid_i = 1'b0;
    stat_set_i  = '0;
    stat_clr_i  = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20417));
    nbr_rdata_i = 64'hDEAD_BEEF_0BAD_F00D;
    port_busy_i = 4'b1010;
    m_stat = 32'h0100_0000;
    m_mask = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(PER/4);
    chk("R1 status", 64'(status_o), 64'h0100_0000);
    chk("R1 irq", 64'(irq_o), 64'h0);
    chk("R1 rvalid", 64'(rvalid_o), 64'h0);
    @(negedge clk);
    step(1, 0, 8, 0, 0, 0, 0, "R1 mask read");
    // R3: unmask command-done (cond bit 8)
    step(1, 1, 8, 0, 64'h0100, 0, 0, "R3");
    // R4: AND drops it, OR adds invalid-command enable
    step(1, 1, 10, 0, 64'hFFFF_FFFF_FFFF_FEFF, 0, 0, "R4");
    step(1, 1, 9, 0, 64'h8000, 0, 0, "R4");
    step(1, 0, 8, 0, 0, 0, 0, "R4 mask read");
    // R8: unknown reads and writes
    step(1, 0, 3, 0, 0, 0, 0, "R8 bad read");
    step(1, 1, 31, 0, 64'h1234, 0, 0, "R8");
    // R2: raw and masked views
    step(1, 0, 9, 0, 0, 0, 0, "R2 raw");
    step(1, 0, 10, 0, 0, 0, 0, "R2 masked");
    // R6: error reset keeps non-error bits
    step(0, 0, 0, 0, 0, 32'h6200_0000, 0, "R6");
    step(1, 1, 12, 0, 0, 0, 0, "R6");
    step(1, 0, 11, 0, 0, 0, 0, "R6 status read");
    // R9: set wins over clear and over error reset
    step(0, 0, 0, 0, 0, 32'h0200_0000, 32'h0200_0000, "R9");
    step(1, 1, 12, 0, 0, 32'h0400_0000, 0, "R9");
    // R5: port map, neighbour pass-through, status
    step(1, 0, 14, 0, 0, 0, 0, "R5 ports");
    step(1, 0, 5, 0, 0, 0, 0, "R5 neighbour");
    step(1, 0, 12, 0, 0, 0, 0, "R5 neighbour ext");
    step(1, 0, 11, 0, 0, 0, 0, "R5 status");
    // R10: low byte-address bits ignored
    step(1, 0, 8, 3'd5, 0, 0, 0, "R10 mask read");
    step(1, 1, 9, 3'd7, 64'h0040, 0, 0, "R10");
    // R7: full reset
    step(1, 1, 11, 0, 0, 0, 0, "R7");
    step(1, 0, 8, 0, 0, 0, 0, "R7 mask read");

    for (int i = 0; i < 600; i++) begin
      int off;
      bit v, we;
      logic [31:0] s, c;
      port_busy_i = 4'($urandom);
      nbr_rdata_i = {$urandom, $urandom};
      off = ($urandom_range(0, 3) != 0) ? 8 + $urandom_range(0, 6) : $urandom_range(0, 31);
      v  = $urandom_range(0, 4) != 0;
      we = $urandom_range(0, 1) == 1;
      if (we && off == 11 && $urandom_range(0, 3) != 0) we = 0;
      s = ($urandom_range(0, 2) == 0) ? (32'h1 << $urandom_range(16, 31)) : 32'h0;
      c = ($urandom_range(0, 2) == 0) ? (32'h1 << $urandom_range(16, 31)) : 32'h0;
      step(v, we, off, 3'($urandom), {$urandom, $urandom}, s, c, "R2 R5 random read");
    end
    finish_run();
  end

endmodule